// File: doc/BRIEF.md
# Debug Halt and Restart Controller

This block keeps track of whether a processor core is running or halted in debug state. It also runs the exit from debug state as a fixed series of steps, one step per clock cycle. Two events put the core into debug state: a debug entry request and a watchpoint hit. Two sources start a restart. One is a debugger write to a run-control word that has the restart bit set. The other is a restart pulse from an external cross-trigger.

The block also decides what happens to each imprecise data abort, based on the context in which it is detected. An abort that the implicit entry barrier finds, or that arrives together with a watchpoint, is held as pending. The core receives it only after it is running again, and only if aborts are unmasked. An abort seen while the core is already in debug state sets a sticky status bit and is otherwise dropped.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: A restart request is the external cross-trigger pulse, or a run-control write whose data bit 1 is set. A run-control write with bit 1 clear does nothing.
- R2: While the core is running, restart requests are ignored. While a restart sequence is in progress, restart requests and debug entry requests are ignored.
- R3: A restart accepted at clock edge E0 runs in this order: `restarted_o` falls after E0, debug state is left after E0+1, `halted_o` falls after E0+2, debug-acknowledge is updated after E0+3, `resume_o` is high for exactly one cycle after E0+4, and `restarted_o` rises after E0+5.
- R4: At the acknowledge step of exit, `dbg_ack_o` takes the value of `ack_override_i`. A value of 1 keeps it high and a value of 0 drives it low.
- R5: An entry request (`halt_req_i` or `wpt_hit_i`) while running sets `halted_o` and `dbg_ack_o` to 1 after the next edge. `restarted_o` stays at 1.
- R6: An abort event (`imp_abort_i` or `barrier_abort_i`) in the entry cycle is recorded as pending. It is not presented to the core while the core is in debug state.
- R7: An abort event in debug state sets `sticky_abort_o`. It leaves `abort_pend_o` unchanged, and so does `abort_taken_i` in that state.
- R8: When a watchpoint and an abort arrive in the same cycle, the core enters debug state and the abort is recorded as pending, not taken.
- R9: `abort_take_o` is `abort_pend_o` gated by the running state and by `abort_mask_i` = 0. `abort_taken_i` clears the pending abort only while it is presented. An abort event while running, outside entry, is recorded as pending.
- R10: `sticky_abort_o` holds until `sticky_clr_i` is pulsed. A new abort event in the same cycle as the clear wins. A restart does not clear it.
- R11: After reset, `halted_o`=0, `restarted_o`=1, `dbg_ack_o`=0, `resume_o`=0, `abort_pend_o`=0, `abort_take_o`=0 and `sticky_abort_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_req_i | input | 1 | Debug entry request pulse |
| ctl_wr_i | input | 1 | Run-control word write strobe |
| ctl_wdata_i | input | CTL_W | Run-control write data; bit 1 requests a restart |
| xtrig_restart_i | input | 1 | External cross-trigger restart pulse |
| ack_override_i | input | 1 | Keeps debug-acknowledge high on exit |
| wpt_hit_i | input | 1 | Watchpoint hit pulse |
| barrier_abort_i | input | 1 | Abort reported by a barrier operation |
| imp_abort_i | input | 1 | Imprecise data abort pulse |
| sticky_clr_i | input | 1 | Write-one-to-clear for the sticky abort bit |
| abort_mask_i | input | 1 | Core abort-mask state |
| abort_taken_i | input | 1 | Core exception logic took the presented abort |
| halted_o | output | 1 | Core halted flag |
| restarted_o | output | 1 | Core restarted flag |
| sticky_abort_o | output | 1 | Sticky abort-in-debug status |
| dbg_ack_o | output | 1 | Debug acknowledge |
| abort_pend_o | output | 1 | Recorded pending abort |
| abort_take_o | output | 1 | Pending abort presented to the core |
| resume_o | output | 1 | Resume-execution strobe |

## Verification
The assertions check the following on every cycle. The restart steps never run out of order: `halted_o` cannot fall while `restarted_o` is high, `resume_o` is a single pulse, and `restarted_o` rises only right after it. The pending abort stays frozen for the whole time the core is in debug state. An abort presented to the core only appears while the core is running, and aborts in debug state always set the sticky bit. Some behaviours show up only in the bench scenarios, because they depend on whole event sequences: the exact cycle of each exit step, a cross-trigger or run-control write being ignored in the middle of a sequence, the sticky bit surviving a full restart, and the watchpoint-with-abort case leading to a presented abort once the core is running again.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_HALT,
    ST_LEAVE,
    ST_CLRH,
    ST_ACK,
    ST_RESUME,
    ST_DONE
  } seq_st_t;

  // Restart request from either source.
  function automatic logic restart_hit(input logic wr, input logic bit_val,
                                       input logic xtrig);
    return (wr & bit_val) | xtrig;
  endfunction

  // Next step of the exit chain.
  function automatic seq_st_t seq_step(input seq_st_t st);
    case (st)
      ST_HALT:   return ST_LEAVE;
      ST_LEAVE:  return ST_CLRH;
      ST_CLRH:   return ST_ACK;
      ST_ACK:    return ST_RESUME;
      ST_RESUME: return ST_DONE;
      default:   return ST_RUN;
    endcase
  endfunction

  // Abort presented to the core: pending, running, not entering, unmasked.
  function automatic logic abort_present(input logic pend, input logic run,
                                         input logic entering, input logic mask);
    return pend & run & ~entering & ~mask;
  endfunction

endpackage

// File: rtl/dbg_restart_seq.sv
module dbg_restart_seq
  import dbg_halt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enter_i,
  input  logic    restart_i,
  input  logic    ack_ovr_i,
  output logic    halted_o,
  output logic    restarted_o,
  output logic    ack_o,
  output logic    resume_o,
  output logic    in_dbg_o,
  output logic    running_o,
  output logic    entering_o,
  output seq_st_t state_o
);

  seq_st_t st_q;

  assign running_o  = (st_q == ST_RUN);
  assign entering_o = running_o & enter_i;
  assign state_o    = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_RUN;
      halted_o    <= 1'b0;
      restarted_o <= 1'b1;
      ack_o       <= 1'b0;
      resume_o    <= 1'b0;
      in_dbg_o    <= 1'b0;
    end else begin
      resume_o <= 1'b0;
      case (st_q)
        ST_RUN: begin
          if (enter_i) begin
            st_q     <= ST_HALT;
            in_dbg_o <= 1'b1;
            halted_o <= 1'b1;
            ack_o    <= 1'b1;
          end
        end
        ST_HALT: begin
          if (restart_i) begin
            restarted_o <= 1'b0;
            st_q        <= seq_step(st_q);
          end
        end
        ST_LEAVE: begin
          in_dbg_o <= 1'b0;
          st_q     <= seq_step(st_q);
        end
        ST_CLRH: begin
          halted_o <= 1'b0;
          st_q     <= seq_step(st_q);
        end
        ST_ACK: begin
          ack_o <= ack_ovr_i;
          st_q  <= seq_step(st_q);
        end
        ST_RESUME: begin
          resume_o <= 1'b1;
          st_q     <= seq_step(st_q);
        end
        ST_DONE: begin
          restarted_o <= 1'b1;
          st_q        <= seq_step(st_q);
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

endmodule

// File: rtl/dbg_abort_track.sv
module dbg_abort_track
  import dbg_halt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic abort_evt_i,
  input  logic in_dbg_i,
  input  logic running_i,
  input  logic entering_i,
  input  logic mask_i,
  input  logic taken_i,
  input  logic sticky_clr_i,
  output logic pend_o,
  output logic take_o,
  output logic sticky_o
);

  logic record_w;
  logic discard_w;
  logic retire_w;

  assign record_w  = abort_evt_i & ~in_dbg_i;
  assign discard_w = abort_evt_i & in_dbg_i;
  assign take_o    = abort_present(pend_o, running_i, entering_i, mask_i);
  assign retire_w  = take_o & taken_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o   <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      pend_o   <= (pend_o & ~retire_w) | record_w;
      sticky_o <= (sticky_o & ~sticky_clr_i) | discard_w;
    end
  end

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int CTL_W       = 12,
  parameter int RESTART_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_req_i,
  input  logic             ctl_wr_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             xtrig_restart_i,
  input  logic             ack_override_i,
  input  logic             wpt_hit_i,
  input  logic             barrier_abort_i,
  input  logic             imp_abort_i,
  input  logic             sticky_clr_i,
  input  logic             abort_mask_i,
  input  logic             abort_taken_i,
  output logic             halted_o,
  output logic             restarted_o,
  output logic             sticky_abort_o,
  output logic             dbg_ack_o,
  output logic             abort_pend_o,
  output logic             abort_take_o,
  output logic             resume_o
);

  // Named internal events, exposed for the checker.
  logic    enter_req_w;
  logic    restart_req_w;
  logic    abort_evt_w;
  logic    in_dbg_w;
  logic    running_w;
  logic    entering_w;
  seq_st_t seq_state_w;

  assign enter_req_w   = halt_req_i | wpt_hit_i;
  assign restart_req_w = restart_hit(ctl_wr_i, ctl_wdata_i[RESTART_BIT], xtrig_restart_i);
  assign abort_evt_w   = imp_abort_i | barrier_abort_i;

  dbg_restart_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter_i     (enter_req_w),
    .restart_i   (restart_req_w),
    .ack_ovr_i   (ack_override_i),
    .halted_o    (halted_o),
    .restarted_o (restarted_o),
    .ack_o       (dbg_ack_o),
    .resume_o    (resume_o),
    .in_dbg_o    (in_dbg_w),
    .running_o   (running_w),
    .entering_o  (entering_w),
    .state_o     (seq_state_w)
  );

  dbg_abort_track u_abort (
    .clk          (clk),
    .rst_n        (rst_n),
    .abort_evt_i  (abort_evt_w),
    .in_dbg_i     (in_dbg_w),
    .running_i    (running_w),
    .entering_i   (entering_w),
    .mask_i       (abort_mask_i),
    .taken_i      (abort_taken_i),
    .sticky_clr_i (sticky_clr_i),
    .pend_o       (abort_pend_o),
    .take_o       (abort_take_o),
    .sticky_o     (sticky_abort_o)
  );

endmodule

// File: rtl/dbg_halt_chk.sv
module dbg_halt_chk
  import dbg_halt_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    halted,
  input logic    restarted,
  input logic    ack,
  input logic    resume,
  input logic    pend,
  input logic    take,
  input logic    sticky,
  input logic    sticky_clr,
  input logic    ack_ovr,
  input logic    in_dbg,
  input logic    running,
  input logic    entering,
  input logic    abort_evt,
  input seq_st_t state
);

  assert_restarted_low_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halted) |-> !restarted);

  assert_resume_after_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> (!halted && !restarted && !in_dbg));

  assert_resume_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);

  assert_restarted_after_resume_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restarted) |-> $past(resume));

  assert_ack_override_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK) |=> (ack == $past(ack_ovr)));

  assert_entry_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    entering |=> (halted && ack && in_dbg && restarted));

  assert_running_ignores_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> restarted);

  assert_entry_records_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (entering && abort_evt) |=> (pend && !take));

  assert_debug_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dbg && abort_evt) |=> sticky);

  assert_debug_pend_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_dbg |=> $stable(pend));

  assert_take_running_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (running && pend && !halted));

  assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky && !sticky_clr) |=> sticky);

endmodule

bind dbg_halt_ctrl dbg_halt_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .halted     (halted_o),
  .restarted  (restarted_o),
  .ack        (dbg_ack_o),
  .resume     (resume_o),
  .pend       (abort_pend_o),
  .take       (abort_take_o),
  .sticky     (sticky_abort_o),
  .sticky_clr (sticky_clr_i),
  .ack_ovr    (ack_override_i),
  .in_dbg     (in_dbg_w),
  .running    (running_w),
  .entering   (entering_w),
  .abort_evt  (abort_evt_w),
  .state      (seq_state_w)
);

// File: tb/dbg_halt_ctrl_tb.sv
module dbg_halt_ctrl_tb;

  localparam int CTL_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, ctl_wr = 0, xtrig = 0, ack_ovr = 0, wpt = 0;
  logic bar_ab = 0, imp_ab = 0, st_clr = 0, mask = 0, taken = 0;
  logic [CTL_W-1:0] wdata = '0;
  logic halted, restarted, sticky, ack, pend, take, resume;

  always #4 clk = ~clk;  // 125 MHz

  dbg_halt_ctrl #(.CTL_W(CTL_W), .RESTART_BIT(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .halt_req_i(halt_req), .ctl_wr_i(ctl_wr),
    .ctl_wdata_i(wdata), .xtrig_restart_i(xtrig), .ack_override_i(ack_ovr),
    .wpt_hit_i(wpt), .barrier_abort_i(bar_ab), .imp_abort_i(imp_ab),
    .sticky_clr_i(st_clr), .abort_mask_i(mask), .abort_taken_i(taken),
    .halted_o(halted), .restarted_o(restarted), .sticky_abort_o(sticky),
    .dbg_ack_o(ack), .abort_pend_o(pend), .abort_take_o(take), .resume_o(resume)
  );

  // Expected vector order: {halted, restarted, ack, resume, pend, take, sticky}
  typedef struct {
    string      req;
    logic [6:0] exp;
  } item_t;

  item_t q[$];
  item_t cur;
  int    n_chk = 0;
  int    n_bad = 0;
  logic  done = 1'b0;

  // Monitor: pops one expected item per clock, after the edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      cur = q.pop_front();
      n_chk++;
      if ({halted, restarted, ack, resume, pend, take, sticky} !== cur.exp) begin
        n_bad++;
        $display("FAIL %s: got %b expected %b", cur.req,
                 {halted, restarted, ack, resume, pend, take, sticky}, cur.exp);
      end
    end
  end

  // Driver: called at a negedge with inputs set; pushes expectation for the next edge.
  task automatic cyc(input string r, input logic [6:0] e);
    q.push_back('{req: r, exp: e});
    @(negedge clk);
    halt_req = 0; ctl_wr = 0; wdata = '0; xtrig = 0; wpt = 0;
    bar_ab = 0; imp_ab = 0; st_clr = 0; taken = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc("R11 reset state", 7'b0100000);

    // Restart while running is ignored
    xtrig = 1; cyc("R2 xtrig while running", 7'b0100000);

    // Scenario A: plain halt and restart via run-control write
    halt_req = 1; cyc("R5 entry", 7'b1110000);
    imp_ab = 1;   cyc("R7 abort in debug sets sticky", 7'b1110001);
    cyc("R10 sticky holds", 7'b1110001);
    st_clr = 1;   cyc("R10 sticky clear", 7'b1110000);
    ack_ovr = 0;
    ctl_wr = 1; wdata = 12'h002; cyc("R1 R3 E0 restarted low", 7'b1010000);
    xtrig = 1;  cyc("R2 R3 E1 restart ignored mid sequence", 7'b1010000);
    halt_req = 1; cyc("R2 R3 E2 halted low, entry ignored", 7'b0010000);
    cyc("R4 R3 E3 ack low", 7'b0000000);
    cyc("R3 E4 resume pulse", 7'b0001000);
    cyc("R3 E5 restarted high", 7'b0100000);
    cyc("R2 entry not taken during sequence", 7'b0100000);

    // Scenario B: barrier abort on entry, override kept high
    halt_req = 1; bar_ab = 1; cyc("R6 barrier abort at entry pending", 7'b1110100);
    imp_ab = 1;   cyc("R7 debug abort keeps pending", 7'b1110101);
    taken = 1;    cyc("R7 taken ignored in debug", 7'b1110101);
    ctl_wr = 1; wdata = 12'h001; cyc("R1 write without bit 1 ignored", 7'b1110101);
    ack_ovr = 1;
    xtrig = 1; cyc("R1 R3 xtrig E0", 7'b1010101);
    cyc("R3 E1", 7'b1010101);
    cyc("R3 E2", 7'b0010101);
    cyc("R4 E3 ack held by override", 7'b0010101);
    cyc("R3 E4 resume", 7'b0011101);
    cyc("R9 R10 E5 abort presented, sticky kept", 7'b0110111);
    taken = 1; cyc("R9 taken clears pending", 7'b0110001);
    st_clr = 1; cyc("R10 sticky clear", 7'b0110000);
    ack_ovr = 0;

    // Scenario C: running abort with mask
    mask = 1; imp_ab = 1; cyc("R9 masked running abort pending", 7'b0110100);
    mask = 0; cyc("R9 unmask presents abort", 7'b0110110);
    taken = 1; cyc("R9 taken", 7'b0110000);

    // Scenario D: watchpoint with abort on same access
    wpt = 1; imp_ab = 1; cyc("R8 watchpoint wins, abort pending", 7'b1110100);
    xtrig = 1; cyc("R8 E0", 7'b1010100);
    cyc("R8 E1", 7'b1010100);
    cyc("R8 E2", 7'b0010100);
    cyc("R4 E3 ack low", 7'b0000100);
    cyc("R8 E4", 7'b0001100);
    cyc("R8 E5 abort presented", 7'b0100110);
    taken = 1; cyc("R9 taken", 7'b0100000);

    // Scenario E: sticky set and clear in same cycle
    halt_req = 1; cyc("R5 entry", 7'b1110000);
    imp_ab = 1; st_clr = 1; cyc("R10 set wins over clear", 7'b1110001);

    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule